// File: doc/BRIEF.md
# Spare-Area Buffer Address Mapper

A NAND controller keeps the out-of-band bytes of one page in a row of small spare buffers, one buffer for each 512-byte chunk of the page. Software sees the spare area as one linear range of bytes. This block turns a linear spare-area request into a series of physical segments. Each segment gives a buffer index, an offset inside that buffer, a length and the matching controller-memory address.

Every buffer holds an even share of the spare area. The share is the spare size divided by the number of chunks, with bit 0 cleared. Bytes that the even shares do not cover spill into the last buffer, because the buffer index never goes past the top buffer.

A request is a start offset and a length. It enters through a valid/ready handshake. The block then finds the first buffer by stepping through the buffers one at a time, so it needs no divider. After that it emits one segment per accepted cycle and flags the final one. Page size and spare size are static configuration inputs.

Top module: `spare_buf_mapper`

## Requirements
- R1: After reset, `req_ready` is 1 and `seg_valid` is 0.
- R2: The share is `cfg_spare` shifted right by 0, 2 or 3, with bit 0 cleared. `cfg_page` selects the shift: 0 means a 512-byte page (shift 0), 1 means 2048 bytes (shift 2), and 2 or 3 mean 4096 bytes (shift 3).
- R3: The buffer index of a segment is its linear offset divided by the share, clamped to 7 (the top of 8 buffers). Within one request the index never decreases.
- R4: The in-buffer offset is the linear offset minus the buffer index times the share.
- R5: A segment's length is the smaller of (share minus in-buffer offset) and the bytes still requested. When the in-buffer offset is at or beyond the share, the length is all remaining bytes. A length is never zero.
- R6: `seg_addr` equals 0x1000 + 64 × buffer index + in-buffer offset.
- R7: Segments are contiguous. Their lengths sum to the request length, `seg_last` marks the final one, and `req_ready` returns in the cycle after that segment is accepted.
- R8: A zero-length request is accepted, produces no segment, and leaves `req_ready` high.
- R9: `req_ready` is low while a request is in flight. While `seg_valid` is high and `seg_ready` is low, all segment outputs hold steady.
- R10: When the share is zero, the whole request is one segment in buffer 7, with in-buffer offset equal to the start offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_page | input | 2 | Page size select (0: 512, 1: 2048, 2/3: 4096) |
| cfg_spare | input | SPARE_W | Spare bytes per page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, accepts a request |
| req_off | input | OFF_W | Start offset into the spare area |
| req_len | input | OFF_W | Number of bytes requested |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Segment taken by the consumer |
| seg_buf | output | IDX_W | Spare buffer index |
| seg_off | output | OFF_W | Offset inside that buffer |
| seg_len | output | OFF_W | Segment byte count |
| seg_last | output | 1 | Final segment of the request |
| seg_addr | output | ADDR_W | Controller-memory byte address |

## Verification
The assertions check, on every cycle, the handshake rules:
- idle and emitting never overlap;
- segment outputs hold still under backpressure;
- a segment is never empty;
- a request returns to idle after its last segment;
- a zero-length request stays idle;
- the buffer index stays ordered within a request.

Only the bench's scenarios can show that the arithmetic is correct. They compare every index, offset, length and address against a division-based model. The scenarios cover several page/spare combinations, the spill into the clamped top buffer, and the degenerate zero-share case.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEEK, ST_EMIT} sbm_state_e;
  localparam logic [1:0] PG_512 = 2'd0;
  localparam logic [1:0] PG_2K  = 2'd1;
endpackage

// File: rtl/sbm_share.sv
module sbm_share #(
  parameter int SPARE_W = 8
) (
  input  logic [1:0]         cfg_page,
  input  logic [SPARE_W-1:0] cfg_spare,
  output logic [SPARE_W-1:0] share
);
  import sbm_pkg::*;

  function automatic logic [SPARE_W-1:0] f_share(input logic [1:0] pg,
                                                 input logic [SPARE_W-1:0] sp);
    logic [SPARE_W-1:0] s;
    case (pg)
      PG_512:  s = sp;
      PG_2K:   s = sp >> 2;
      default: s = sp >> 3;
    endcase
    s[0] = 1'b0;
    return s;
  endfunction

  assign share = f_share(cfg_page, cfg_spare);
endmodule

// File: rtl/sbm_seg_calc.sv
module sbm_seg_calc #(
  parameter int          OFF_W    = 12,
  parameter int          SPARE_W  = 8,
  parameter int          NUM_BUFS = 8,
  parameter int          WIN      = 64,
  parameter int          ADDR_W   = 16,
  parameter int unsigned BASE     = 32'h1000,
  localparam int         IDX_W    = $clog2(NUM_BUFS),
  localparam int         WIN_LG   = $clog2(WIN)
) (
  input  logic [OFF_W-1:0]   cur_off,
  input  logic [OFF_W-1:0]   base_off,
  input  logic [IDX_W-1:0]   idx,
  input  logic [OFF_W-1:0]   rem,
  input  logic [SPARE_W-1:0] share,
  output logic [OFF_W-1:0]   in_off,
  output logic [OFF_W-1:0]   len,
  output logic               last,
  output logic               buf_done,
  output logic [ADDR_W-1:0]  addr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

  function automatic logic [OFF_W-1:0] f_len(input logic [OFF_W-1:0] o,
                                             input logic [SPARE_W-1:0] sh,
                                             input logic [OFF_W-1:0] r);
    logic [OFF_W-1:0] room;
    if (o >= OFF_W'(sh)) return r;
    room = OFF_W'(sh) - o;
    return (room < r) ? room : r;
  endfunction

  logic [OFF_W:0] end_off;
  logic [OFF_W:0] buf_end;

  assign in_off   = cur_off - base_off;
  assign len      = f_len(in_off, share, rem);
  assign last     = (len == rem);
  assign end_off  = {1'b0, cur_off} + {1'b0, len};
  assign buf_end  = {1'b0, base_off} + (OFF_W+1)'(share);
  assign buf_done = (idx != LAST_IDX) && (end_off >= buf_end);
  assign addr     = ADDR_W'(BASE) + (ADDR_W'(idx) << WIN_LG) + ADDR_W'(in_off);
endmodule

// File: rtl/spare_buf_mapper.sv
module spare_buf_mapper #(
  parameter int          OFF_W    = 12,
  parameter int          SPARE_W  = 8,
  parameter int          NUM_BUFS = 8,
  parameter int          WIN      = 64,
  parameter int          ADDR_W   = 16,
  parameter int unsigned BASE     = 32'h1000,
  localparam int         IDX_W    = $clog2(NUM_BUFS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_page,
  input  logic [SPARE_W-1:0] cfg_spare,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OFF_W-1:0]   req_off,
  input  logic [OFF_W-1:0]   req_len,
  output logic               seg_valid,
  input  logic               seg_ready,
  output logic [IDX_W-1:0]   seg_buf,
  output logic [OFF_W-1:0]   seg_off,
  output logic [OFF_W-1:0]   seg_len,
  output logic               seg_last,
  output logic [ADDR_W-1:0]  seg_addr
);
  import sbm_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BUFS - 1);

  sbm_state_e         state;
  logic [OFF_W-1:0]   cur_off, rem, base_off;
  logic [IDX_W-1:0]   idx;
  logic [SPARE_W-1:0] share;
  logic               buf_done;

  // named events for the checker
  logic accept_req, seg_fire, seek_step;

  sbm_share #(.SPARE_W(SPARE_W)) u_share (
    .cfg_page(cfg_page), .cfg_spare(cfg_spare), .share(share)
  );

  sbm_seg_calc #(
    .OFF_W(OFF_W), .SPARE_W(SPARE_W), .NUM_BUFS(NUM_BUFS),
    .WIN(WIN), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_calc (
    .cur_off(cur_off), .base_off(base_off), .idx(idx), .rem(rem),
    .share(share), .in_off(seg_off), .len(seg_len), .last(seg_last),
    .buf_done(buf_done), .addr(seg_addr)
  );

  assign req_ready  = (state == ST_IDLE);
  assign seg_valid  = (state == ST_EMIT);
  assign seg_buf    = idx;
  assign accept_req = req_valid && req_ready;
  assign seg_fire   = seg_valid && seg_ready;
  assign seek_step  = (state == ST_SEEK) && (idx != LAST_IDX) &&
                      ({1'b0, cur_off} >= ({1'b0, base_off} + (OFF_W+1)'(share)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_off  <= '0;
      rem      <= '0;
      base_off <= '0;
      idx      <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept_req) begin
          cur_off  <= req_off;
          rem      <= req_len;
          base_off <= '0;
          idx      <= '0;
          if (req_len != '0) state <= ST_SEEK;
        end
        ST_SEEK: if (seek_step) begin
          idx      <= idx + 1'b1;
          base_off <= base_off + OFF_W'(share);
        end else begin
          state <= ST_EMIT;
        end
        ST_EMIT: if (seg_ready) begin
          cur_off <= cur_off + seg_len;
          rem     <= rem - seg_len;
          if (seg_last) begin
            state <= ST_IDLE;
          end else if (buf_done) begin
            idx      <= idx + 1'b1;
            base_off <= base_off + OFF_W'(share);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int          OFF_W  = 12,
  parameter int          IDX_W  = 3,
  parameter int          ADDR_W = 16,
  parameter int unsigned BASE   = 32'h1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [OFF_W-1:0]  req_len,
  input logic              accept_req,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic              seg_fire,
  input logic [IDX_W-1:0]  seg_buf,
  input logic [OFF_W-1:0]  seg_off,
  input logic [OFF_W-1:0]  seg_len,
  input logic              seg_last,
  input logic [ADDR_W-1:0] seg_addr
);
  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !req_ready);
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_buf) && $stable(seg_off)
                                && $stable(seg_len) && $stable(seg_addr) && $stable(seg_last));
  // R5
  seg_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_len != '0);
  // R7
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire && seg_last |=> req_ready && !seg_valid);
  // R8
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_req && req_len == '0 |=> req_ready && !seg_valid);
  // R3
  buf_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_fire && !seg_last |=> seg_valid && seg_buf >= $past(seg_buf));
  // R6
  addr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> seg_addr >= ADDR_W'(BASE));
endmodule

bind spare_buf_mapper sbm_checker #(
  .OFF_W(OFF_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_len(req_len),
  .accept_req(accept_req), .seg_valid(seg_valid), .seg_ready(seg_ready),
  .seg_fire(seg_fire), .seg_buf(seg_buf), .seg_off(seg_off), .seg_len(seg_len),
  .seg_last(seg_last), .seg_addr(seg_addr)
);

// File: tb/spare_buf_mapper_tb.sv
module spare_buf_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_page = 2'd0;
  logic [7:0]  cfg_spare = 8'd16;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_off = '0;
  logic [11:0] req_len = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [2:0]  seg_buf;
  logic [11:0] seg_off;
  logic [11:0] seg_len;
  logic        seg_last;
  logic [15:0] seg_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spare_buf_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_page(cfg_page), .cfg_spare(cfg_spare),
    .req_valid(req_valid), .req_ready(req_ready), .req_off(req_off),
    .req_len(req_len), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_buf(seg_buf), .seg_off(seg_off), .seg_len(seg_len),
    .seg_last(seg_last), .seg_addr(seg_addr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R2: share model
  function automatic int model_share(input int pg, input int sp);
    int sh = (pg == 0) ? 0 : (pg == 1) ? 2 : 3;
    return (sp >> sh) & ~1;
  endfunction

  task automatic run_req(input int pg, input int sp, input int off, input int len,
                         input bit stall);
    int share = model_share(pg, sp);
    int o_lin = off;
    int remain = len;
    cfg_page = 2'(pg); cfg_spare = 8'(sp);
    @(negedge clk);
    check("R9 ready before request", int'(req_ready), 1);
    req_valid = 1'b1; req_off = 12'(off); req_len = 12'(len);
    @(negedge clk);
    req_valid = 1'b0;
    while (remain > 0) begin
      int s, o, bl, waits;
      s = (share == 0) ? 7 : o_lin / share;
      if (s > 7) s = 7;
      o = o_lin - s * share;
      bl = (o >= share) ? remain : ((share - o < remain) ? share - o : remain);
      waits = 0;
      while (!seg_valid && waits < 20) begin @(negedge clk); waits++; end
      check("R9 segment appears", int'(seg_valid), 1);
      check("R9 busy", int'(req_ready), 0);
      check("R3 buffer index", int'(seg_buf), s);
      check("R4 in-buffer offset", int'(seg_off), o);
      check("R5 segment length", int'(seg_len), bl);
      check("R6 address", int'(seg_addr), 'h1000 + s * 64 + o);
      check("R7 last flag", int'(seg_last), int'(bl == remain));
      if (stall) begin
        @(negedge clk);
        check("R9 held buffer", int'(seg_buf), s);
        check("R9 held length", int'(seg_len), bl);
        check("R9 held address", int'(seg_addr), 'h1000 + s * 64 + o);
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      o_lin += bl;
      remain -= bl;
    end
    check("R7 ready after last", int'(req_ready), 1);
    check("R7 no extra segment", int'(seg_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 reset ready", int'(req_ready), 1);
    check("R1 reset valid", int'(seg_valid), 0);
  endtask

  task automatic t_share_2k();
    run_req(1, 64, 10, 30, 1'b0);   // share 16, three segments
    run_req(1, 64, 0, 64, 1'b0);    // whole area, four full buffers
  endtask

  task automatic t_spill_4k();
    run_req(2, 218, 170, 48, 1'b0); // share 26, spill into clamped buffer 7
    run_req(3, 218, 0, 218, 1'b0);  // whole uneven area, encoding 3
  endtask

  task automatic t_clamp_512();
    run_req(0, 16, 5, 20, 1'b0);    // share 16
    run_req(0, 16, 100, 40, 1'b0);  // beyond eight shares: clamp R3
  endtask

  task automatic t_zero_len();
    cfg_page = 2'd1; cfg_spare = 8'd64;
    @(negedge clk);
    req_valid = 1'b1; req_off = 12'd7; req_len = 12'd0;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 ready after zero length", int'(req_ready), 1);
    check("R8 no segment", int'(seg_valid), 0);
    @(negedge clk);
    check("R8 still no segment", int'(seg_valid), 0);
  endtask

  task automatic t_stall();
    run_req(2, 128, 20, 40, 1'b1);  // share 16 with backpressure on every segment
  endtask

  task automatic t_share_zero();
    // R10: 6 >> 3 = 0
    run_req(2, 6, 9, 5, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_share_2k();
    t_spill_4k();
    t_clamp_512();
    t_zero_len();
    t_stall();
    t_share_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule